// File: doc/BRIEF.md
# Aliased Control and Status Register Bank

This block is a bank of ten 32-bit registers on a simple valid/ready register bus with byte addresses. Every register has a 16-byte window of four words. The first word replaces the register. The other three OR in, AND-NOT out, or XOR the 1 bits of the write data. Software can therefore change single bits without a read-modify-write.

One register holds status flags. Hardware sets its bits, and software clears them by writing ones through the clear word. The contents of all registers leave the block on one flat vector, so the function they control can use them. Out of reset the registers hold fixed values. The two calibration words reset to their factory values, so they are valid before any calibration is loaded.

A two-state bus machine handles each transfer. In ST_IDLE the bus is ready. The ACCEPT transition (valid while ready) applies a write, or captures the read value, and moves to ST_RESP. ST_RESP presents the response for one cycle. The RETIRE transition always returns to ST_IDLE.

Top module: `regfile_alias_top`

## Requirements
- R1: After reset, every register is 0 except calibration word A (0xB561BC2D) and calibration word B (0x000065D4). `regs_q` carries register k in bits [32k+31:32k], in this order: k=0 mode A, 1 status flags, 2 sample, 3 limit, 4 mode B, 5 interval, 6 clock divider, 7 settle delay, 8 calibration A, 9 calibration B.
- R2: A write to window word 0 (`req_addr[3:2]`=0) replaces the register with the write data.
- R3: A write to word 1 (`req_addr[3:2]`=1) ORs the write data into the register.
- R4: A write to word 2 (`req_addr[3:2]`=2) clears the register bits where the write data is 1.
- R5: A write to word 3 (`req_addr[3:2]`=3) inverts the register bits where the write data is 1.
- R6: A read from any of the four words of a window returns the register value at the accepting edge. A write response returns zero read data.
- R7: A 1 on a `hw_flag_set` bit sets that status flag at the next edge. A write to the clear word of the status window clears the flags written as 1. Writes to the other three status words are ignored.
- R8: When a hardware set and a software clear hit the same status bit in the same cycle, the bit ends set.
- R9: An address that is not in a window, or whose bits [1:0] are not zero, is ignored on write and reads as zero.
- R10: `req_ready` is high only in ST_IDLE. `resp_valid` is high for exactly the one cycle after ACCEPT, and `req_ready` is low during that cycle. A write's effect shows on `regs_q` in that same cycle.
- R11: The window bases are 0x000, 0x010, 0x020, 0x030, 0x200, 0x270, 0x280, 0x2B0, 0x2E0 and 0x2F0, for registers k=0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Response cycle |
| resp_rdata | output | DATA_W | Read data |
| hw_flag_set | input | DATA_W | Per-bit status flag set |
| regs_q | output | 10*DATA_W | All register contents |

## Verification
Directed writes put distinct patterns through each of the four words of every window. Each pattern has a bit pattern that separates replace, OR, AND-NOT and XOR from one another. The status window is tried with set pulses alone, with clears alone, with the two colliding on one bit, and with the ignored words. These cases tell write-1-to-clear apart from the plain control behaviour. Misaligned addresses and gap addresses between windows check that the decode is tight. A seeded random mix of reads, writes, aliases and set pulses then runs against a bench model of all ten registers.

// File: rtl/regfile_alias_pkg.sv
package regfile_alias_pkg;

    localparam int NREG       = 10;
    localparam int STATUS_IDX = 1;

    typedef enum logic [1:0] {
        AL_WRITE  = 2'd0,
        AL_SET    = 2'd1,
        AL_CLEAR  = 2'd2,
        AL_TOGGLE = 2'd3
    } alias_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    // Window base of each register (byte address, 16-byte aligned)
    function automatic logic [11:0] reg_offset(input int idx);
        logic [11:0] r;
        unique case (idx)
            0:       r = 12'h000;
            1:       r = 12'h010;
            2:       r = 12'h020;
            3:       r = 12'h030;
            4:       r = 12'h200;
            5:       r = 12'h270;
            6:       r = 12'h280;
            7:       r = 12'h2B0;
            8:       r = 12'h2E0;
            default: r = 12'h2F0;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] reg_default(input int idx);
        logic [31:0] r;
        unique case (idx)
            8:       r = 32'hB561_BC2D;
            9:       r = 32'h0000_65D4;
            default: r = 32'h0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/regfile_alias_decode.sv
module regfile_alias_decode
    import regfile_alias_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int N      = NREG
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N-1:0]      hit,
    output alias_e            word_sel
);
    logic aligned;
    assign aligned  = (addr[1:0] == 2'b00);
    assign word_sel = alias_e'(addr[3:2]);

    for (genvar g = 0; g < N; g++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(reg_offset(g));
        assign hit[g] = aligned && (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
    end
endmodule

// File: rtl/regfile_alias_cell.sv
module regfile_alias_cell
    import regfile_alias_pkg::*;
#(
    parameter int              DATA_W    = 32,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  alias_e            word_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] nxt;

    always_comb begin
        unique case (word_sel)
            AL_WRITE:  nxt = wdata;
            AL_SET:    nxt = q | wdata;
            AL_CLEAR:  nxt = q & ~wdata;
            AL_TOGGLE: nxt = q ^ wdata;
            default:   nxt = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= RESET_VAL;
        else if (wr_en) q <= nxt;
    end
endmodule

// File: rtl/regfile_alias_flags.sv
module regfile_alias_flags
    import regfile_alias_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  alias_e            word_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_set,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] clr_mask;

    // Only the clear word acts; hardware set wins a same-cycle collision
    assign clr_mask = (wr_en && word_sel == AL_CLEAR) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= (q & ~clr_mask) | hw_set;
    end
endmodule

// File: rtl/regfile_alias_bus.sv
module regfile_alias_bus
    import regfile_alias_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] rd_value,
    output logic              req_ready,
    output logic              accept,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata
);
    bus_state_e state_q, state_d;

    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP; // ACCEPT
            ST_RESP: state_d = ST_IDLE;                // RETIRE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready  = 1'b1;
            ST_RESP: resp_valid = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      resp_rdata <= '0;
        else if (accept) resp_rdata <= req_write ? '0 : rd_value;
    end
endmodule

// File: rtl/regfile_alias_top.sv
module regfile_alias_top
    import regfile_alias_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   resp_valid,
    output logic [DATA_W-1:0]      resp_rdata,
    input  logic [DATA_W-1:0]      hw_flag_set,
    output logic [NREG*DATA_W-1:0] regs_q
);
    logic [NREG-1:0]   hit;
    alias_e            word_sel;
    logic              accept;
    logic [DATA_W-1:0] rd_value;
    logic [DATA_W-1:0] q [NREG];

    regfile_alias_decode #(.ADDR_W(ADDR_W), .N(NREG)) u_decode (
        .addr     (req_addr),
        .hit      (hit),
        .word_sel (word_sel)
    );

    regfile_alias_bus #(.DATA_W(DATA_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .rd_value   (rd_value),
        .req_ready  (req_ready),
        .accept     (accept),
        .resp_valid (resp_valid),
        .resp_rdata (resp_rdata)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DATA_W-1:0] RV = DATA_W'(reg_default(g));
        logic wr_en;
        assign wr_en = accept && req_write && hit[g];

        if (g == STATUS_IDX) begin : g_flags
            regfile_alias_flags #(.DATA_W(DATA_W), .RESET_VAL(RV)) u_flags (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_en),
                .word_sel (word_sel),
                .wdata    (req_wdata),
                .hw_set   (hw_flag_set),
                .q        (q[g])
            );
        end else begin : g_ctrl
            regfile_alias_cell #(.DATA_W(DATA_W), .RESET_VAL(RV)) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_en),
                .word_sel (word_sel),
                .wdata    (req_wdata),
                .q        (q[g])
            );
        end
        assign regs_q[g*DATA_W +: DATA_W] = q[g];
    end

    always_comb begin
        rd_value = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) rd_value = q[i];
        end
    end
endmodule

// File: rtl/regfile_alias_chk.sv
module regfile_alias_chk
    import regfile_alias_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic                   req_write,
    input logic [ADDR_W-1:0]      req_addr,
    input logic [DATA_W-1:0]      req_wdata,
    input logic                   resp_valid,
    input logic [DATA_W-1:0]      resp_rdata,
    input logic [DATA_W-1:0]      hw_flag_set,
    input logic [NREG*DATA_W-1:0] regs_q
);
    logic [DATA_W-1:0] flags;
    assign flags = regs_q[STATUS_IDX*DATA_W +: DATA_W];

    p_ready_off_in_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    p_resp_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    p_resp_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_hw_set_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_flag_set != '0) |=> ((flags & $past(hw_flag_set)) == $past(hw_flag_set)));

    p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_flag_set == '0 && !(req_valid && req_ready)) |=> $stable(flags));

    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready && req_write) |=> $stable(regs_q[DATA_W-1:0]));

    p_write_resp_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> (resp_rdata == '0));
endmodule

bind regfile_alias_top regfile_alias_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/regfile_alias_top_bench.sv
`timescale 1ns/100ps
module regfile_alias_top_bench;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NR = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic            resp_valid;
    logic [DW-1:0]   resp_rdata;
    logic [DW-1:0]   hw_flag_set = '0;
    logic [NR*DW-1:0] regs_q;

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] model [NR];

    always #2.5 clk = ~clk;

    regfile_alias_top u_regfile_alias_top (.*);

    function automatic logic [11:0] base_of(input int k);
        logic [11:0] t [NR] = '{12'h000, 12'h010, 12'h020, 12'h030, 12'h200,
                                12'h270, 12'h280, 12'h2B0, 12'h2E0, 12'h2F0};
        return t[k];
    endfunction

    function automatic int index_of(input logic [11:0] a);
        if (a[1:0] != 2'b00) return -1;
        for (int k = 0; k < NR; k++)
            if (a[11:4] == base_of(k)[11:4]) return k;
        return -1;
    endfunction

    function automatic logic [DW-1:0] apply_word(input logic [1:0] w,
                                                 input logic [DW-1:0] o,
                                                 input logic [DW-1:0] d);
        case (w)
            2'd0:    return d;
            2'd1:    return o | d;
            2'd2:    return o & ~d;
            default: return o ^ d;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int k = 0; k < NR; k++)
            check(regs_q[k*DW +: DW] === model[k], tag, regs_q[k*DW +: DW], model[k]);
    endtask

    task automatic txn(input bit wr, input logic [11:0] a, input logic [DW-1:0] d,
                       input logic [DW-1:0] hw, input string tag);
        int k;
        logic [DW-1:0] exp_rd;
        @(negedge clk);
        check(req_ready === 1'b1, "R10 ready", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; hw_flag_set = hw;
        k = index_of(a);
        exp_rd = (!wr && k >= 0) ? model[k] : '0;
        if (wr && k >= 0 && k != 1) model[k] = apply_word(a[3:2], model[k], d);
        if (wr && k == 1 && a[3:2] == 2'd2) model[1] = model[1] & ~d;
        model[1] = model[1] | hw;
        @(negedge clk);
        req_valid = 1'b0; hw_flag_set = '0;
        check(resp_valid === 1'b1 && req_ready === 1'b0, "R10 resp",
              {30'b0, resp_valid, req_ready}, 32'd2);
        check(resp_rdata === exp_rd, wr ? "R6 write resp" : tag, resp_rdata, exp_rd);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < NR; k++) model[k] = '0;
        model[8] = 32'hB561_BC2D;
        model[9] = 32'h0000_65D4;
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R11 map, R2 plain write, R6 readback on each word
        for (int k = 0; k < NR; k++)
            if (k != 1) txn(1, base_of(k), 32'hA5000000 | k, '0, "R11 map write");
        for (int k = 0; k < NR; k++)
            for (int w = 0; w < 4; w++)
                txn(0, base_of(k) | 12'(w * 4), '0, '0, "R6 R11 read");
        // R3 / R4 / R5 on limit register
        txn(1, 12'h030, 32'hF0F0_0000, '0, "R2 write");
        txn(1, 12'h034, 32'h0000_00FF, '0, "R3 set");
        txn(1, 12'h038, 32'hF000_000F, '0, "R4 clear");
        txn(1, 12'h03C, 32'hFFFF_FFFF, '0, "R5 toggle");
        // R7 status flags
        txn(0, 12'h000, '0, 32'h0000_0201, "R7 hw set");
        txn(1, 12'h010, 32'hFFFF_FFFF, '0, "R7 plain ignored");
        txn(1, 12'h014, 32'hFFFF_0000, '0, "R7 set ignored");
        txn(1, 12'h01C, 32'hFFFF_FFFF, '0, "R7 toggle ignored");
        txn(1, 12'h018, 32'h0000_0001, '0, "R7 clear");
        // R8 collision
        txn(1, 12'h018, 32'h0001_0200, 32'h0001_0000, "R8 set wins");
        // R9 undecoded and misaligned
        txn(1, 12'h100, 32'hDEAD_BEEF, '0, "R9 gap write");
        txn(0, 12'h100, '0, '0, "R9 gap read");
        txn(1, 12'h201, 32'h1234_5678, '0, "R9 misaligned write");
        txn(0, 12'h032, '0, '0, "R9 misaligned read");
        txn(0, 12'h2C0, '0, '0, "R9 gap read");

        // Seeded random mix
        for (int n = 0; n < 400; n++) begin
            logic [11:0] a;
            logic [DW-1:0] hw;
            bit wr;
            int r = $urandom_range(0, 11);
            if (r < NR) a = base_of(r) | 12'($urandom_range(0, 3) * 4);
            else        a = 12'($urandom_range(0, 4095));
            wr = $urandom_range(0, 1);
            hw = ($urandom_range(0, 3) == 0) ? 32'($urandom) : '0;
            txn(wr, a, 32'($urandom), hw, "R2 R3 R4 R5 R7 R9 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule